// File: doc/BRIEF.md
# Rectangle Blit Setup Register Front-End

This block sits between a 32-bit register bus and a 2D rectangle drawing engine. Software programs source and destination coordinates, rectangle size, surface offsets, pitches and drawing-control words through single-field registers and through packed aliases that load two fields in one write. Certain writes start an operation. The block then issues a one-cycle start pulse together with a frozen copy of every parameter, so the engine can use the values while software sets up the next operation.

The engine reports that it is still working through a busy input. A start request that arrives while busy is held as pending and is issued as soon as busy falls. All registers can be read back on a combinational read port addressed by word index.

Top module: `blit_setup_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, `blit_start` is low and every snapshot output is 0.
- R2: Single-field coordinate writes keep bits 13:0 only. Word addresses: 0x00 source X, 0x01 source Y, 0x02 destination X, 0x03 destination Y, 0x04 width, 0x05 height. The same addresses read the stored value, zero-extended.
- R3: A write to the width register (0x04) requests a start. Writes to 0x00, 0x01, 0x02, 0x03 and 0x05 never request one.
- R4: Three packed aliases request a start. 0x10 loads width from bits 13:0 and height from bits 29:16. 0x11 loads height from bits 13:0 and width from bits 29:16. 0x12 loads destination X from bits 13:0 and width from bits 29:16.
- R5: Five packed aliases never request a start. 0x13 loads destination Y from bits 13:0 and height from bits 29:16. 0x0C (source) and 0x0D (destination) load X from bits 13:0 and Y from bits 29:16. 0x0E (source) and 0x0F (destination) load Y from bits 13:0 and X from bits 29:16.
- R6: Packed surface writes (0x0A source, 0x0B destination) set offset = bits 20:0 shifted left by 5, pitch = bits 30:21 and tile = bit 31.
- R7: Offset writes (0x06 source, 0x08 destination) clear bits 3:0. Pitch writes (0x07 source, 0x09 destination) keep pitch bits 13:0 and tile from bit 16. A pitch read returns the pitch in bits 13:0 and tile in bit 16.
- R8: A control write (0x14) stores bits 31:27 and 3:0. The same write rebuilds the datatype register (0x15) and the mix register (0x16). Datatype bits 3:0 take control bits 11:8, bits 11:8 take bits 7:4, bits 17:16 take bits 13:12, and bit 30 takes bit 14. Mix bits 23:16 take control bits 23:16 and mix bits 10:8 take bits 26:24. Direct writes to 0x15 and 0x16 are masked with 0xE0070F0F and 0x00FF0700.
- R9: When the engine is idle, `blit_start` is high for exactly the one cycle after the requesting write. The snapshot outputs carry the values that include that write and hold until the next start.
- R10: While `eng_busy` is high no start is issued. A start request made while busy is remembered and is issued in the cycle after busy is sampled low, with the register values current at that moment.
- R11: Writes to unmapped addresses change nothing. Reads of unmapped or alias-only addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| eng_busy | input | 1 | Engine still working |
| blit_start | output | 1 | One-cycle start pulse |
| out_src_x | output | 14 | Snapshot source X |
| out_src_y | output | 14 | Snapshot source Y |
| out_dst_x | output | 14 | Snapshot destination X |
| out_dst_y | output | 14 | Snapshot destination Y |
| out_width | output | 14 | Snapshot width |
| out_height | output | 14 | Snapshot height |
| out_src_offset | output | 32 | Snapshot source offset |
| out_src_pitch | output | 14 | Snapshot source pitch |
| out_src_tile | output | 1 | Snapshot source tile flag |
| out_dst_offset | output | 32 | Snapshot destination offset |
| out_dst_pitch | output | 14 | Snapshot destination pitch |
| out_dst_tile | output | 1 | Snapshot destination tile flag |
| out_datatype | output | 32 | Snapshot datatype word |
| out_mix | output | 32 | Snapshot mix word |

## Verification
The bench covers every packed alias and checks each half-word lands in the correct field. A design that swapped the halves of any alias would read back the wrong coordinate. A design that started on the height-or-Y aliases would pulse where none is expected. The bench checks that the snapshot already holds the value from the triggering write, which catches a snapshot taken from the old register contents. It also checks that a start requested while busy appears exactly once after busy falls, carrying coordinates written during the wait. A design that dropped the request, fired early or fired twice fails that check.

// File: rtl/blit_setup_pkg.sv
// Shared constants for the blit setup front-end: register word addresses,
// coordinate slot indices, surface indices and field remap functions.
// Assumes word-addressed, full 32-bit register accesses.
package blit_setup_pkg;

    localparam int DATA_W     = 32;
    localparam int REG_ADDR_W = 6;
    localparam int N_COORD    = 6;
    localparam int N_SURF     = 2;

    // Coordinate slots; slot index equals the single-field write address
    localparam int CI_SRC_X  = 0;
    localparam int CI_SRC_Y  = 1;
    localparam int CI_DST_X  = 2;
    localparam int CI_DST_Y  = 3;
    localparam int CI_WIDTH  = 4;
    localparam int CI_HEIGHT = 5;

    localparam int SURF_SRC = 0;
    localparam int SURF_DST = 1;

    localparam logic [REG_ADDR_W-1:0] A_DST_W     = 6'h04;
    localparam logic [REG_ADDR_W-1:0] A_DST_H     = 6'h05;
    localparam logic [REG_ADDR_W-1:0] A_SRC_OFFS  = 6'h06;
    localparam logic [REG_ADDR_W-1:0] A_SRC_PITCH = 6'h07;
    localparam logic [REG_ADDR_W-1:0] A_DST_OFFS  = 6'h08;
    localparam logic [REG_ADDR_W-1:0] A_DST_PITCH = 6'h09;
    localparam logic [REG_ADDR_W-1:0] A_SRC_PACK  = 6'h0A;
    localparam logic [REG_ADDR_W-1:0] A_DST_PACK  = 6'h0B;
    localparam logic [REG_ADDR_W-1:0] A_SRC_YX    = 6'h0C;
    localparam logic [REG_ADDR_W-1:0] A_DST_YX    = 6'h0D;
    localparam logic [REG_ADDR_W-1:0] A_SRC_XY    = 6'h0E;
    localparam logic [REG_ADDR_W-1:0] A_DST_XY    = 6'h0F;
    localparam logic [REG_ADDR_W-1:0] A_HT_WD     = 6'h10;
    localparam logic [REG_ADDR_W-1:0] A_WD_HT     = 6'h11;
    localparam logic [REG_ADDR_W-1:0] A_WD_X      = 6'h12;
    localparam logic [REG_ADDR_W-1:0] A_HT_Y      = 6'h13;
    localparam logic [REG_ADDR_W-1:0] A_CTRL      = 6'h14;
    localparam logic [REG_ADDR_W-1:0] A_DTYPE     = 6'h15;
    localparam logic [REG_ADDR_W-1:0] A_MIX       = 6'h16;

    localparam logic [DATA_W-1:0] CTRL_MASK  = 32'hF800_000F;
    localparam logic [DATA_W-1:0] DTYPE_MASK = 32'hE007_0F0F;
    localparam logic [DATA_W-1:0] MIX_MASK   = 32'h00FF_0700;

    // Datatype word derived from a control write
    function automatic logic [DATA_W-1:0] ctrl_to_dtype(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r        = '0;
        r[3:0]   = d[11:8];
        r[11:8]  = d[7:4];
        r[17:16] = d[13:12];
        r[30]    = d[14];
        return r;
    endfunction

    // Mix word derived from a control write
    function automatic logic [DATA_W-1:0] ctrl_to_mix(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r        = '0;
        r[23:16] = d[23:16];
        r[10:8]  = d[26:24];
        return r;
    endfunction

endpackage

// File: rtl/blit_wr_decode.sv
// Write decoder: turns one bus write into per-field write enables and
// values, and flags writes that request an operation start.
// Assumes full-word writes; unmapped addresses produce no enables.
module blit_wr_decode
    import blit_setup_pkg::*;
#(
    parameter int COORD_W = 14,
    parameter int PITCH_W = 14
) (
    input  logic                                 wr_en,
    input  logic [REG_ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [N_COORD-1:0]                   coord_we,
    output logic [N_COORD-1:0][COORD_W-1:0]      coord_wv,
    output logic [N_SURF-1:0]                    offs_we,
    output logic [N_SURF-1:0][DATA_W-1:0]        offs_wv,
    output logic [N_SURF-1:0]                    pitch_we,
    output logic [N_SURF-1:0][PITCH_W-1:0]       pitch_wv,
    output logic [N_SURF-1:0]                    tile_wv,
    output logic                                 ctrl_we,
    output logic [DATA_W-1:0]                    ctrl_wv,
    output logic                                 dtype_we,
    output logic [DATA_W-1:0]                    dtype_wv,
    output logic                                 mix_we,
    output logic [DATA_W-1:0]                    mix_wv,
    output logic                                 start_req
);

    localparam int HI_LSB = 16;
    localparam int CI_W   = $clog2(N_COORD);

    logic [COORD_W-1:0] lo_f;
    logic [COORD_W-1:0] hi_f;
    int                 si;

    assign lo_f = wr_data[COORD_W-1:0];
    assign hi_f = wr_data[HI_LSB +: COORD_W];

    // Decode the write address into field updates and a start request
    always_comb begin
        coord_we  = '0;
        coord_wv  = '0;
        offs_we   = '0;
        offs_wv   = '0;
        pitch_we  = '0;
        pitch_wv  = '0;
        tile_wv   = '0;
        ctrl_we   = 1'b0;
        ctrl_wv   = '0;
        dtype_we  = 1'b0;
        dtype_wv  = '0;
        mix_we    = 1'b0;
        mix_wv    = '0;
        start_req = 1'b0;
        si        = SURF_SRC;
        if (wr_en) begin
            if (wr_addr < REG_ADDR_W'(N_COORD)) begin
                coord_we[wr_addr[CI_W-1:0]] = 1'b1;
                coord_wv[wr_addr[CI_W-1:0]] = lo_f;
                start_req = (wr_addr == A_DST_W);
            end else begin
                case (wr_addr)
                    A_SRC_OFFS, A_DST_OFFS: begin
                        si = (wr_addr == A_DST_OFFS) ? SURF_DST : SURF_SRC;
                        offs_we[si] = 1'b1;
                        offs_wv[si] = {wr_data[DATA_W-1:4], 4'h0};
                    end
                    A_SRC_PITCH, A_DST_PITCH: begin
                        si = (wr_addr == A_DST_PITCH) ? SURF_DST : SURF_SRC;
                        pitch_we[si] = 1'b1;
                        pitch_wv[si] = wr_data[PITCH_W-1:0];
                        tile_wv[si]  = wr_data[16];
                    end
                    A_SRC_PACK, A_DST_PACK: begin
                        si = (wr_addr == A_DST_PACK) ? SURF_DST : SURF_SRC;
                        offs_we[si]  = 1'b1;
                        offs_wv[si]  = DATA_W'({wr_data[20:0], 5'b0});
                        pitch_we[si] = 1'b1;
                        pitch_wv[si] = PITCH_W'(wr_data[30:21]);
                        tile_wv[si]  = wr_data[31];
                    end
                    A_SRC_YX: begin
                        coord_we[CI_SRC_X] = 1'b1; coord_wv[CI_SRC_X] = lo_f;
                        coord_we[CI_SRC_Y] = 1'b1; coord_wv[CI_SRC_Y] = hi_f;
                    end
                    A_DST_YX: begin
                        coord_we[CI_DST_X] = 1'b1; coord_wv[CI_DST_X] = lo_f;
                        coord_we[CI_DST_Y] = 1'b1; coord_wv[CI_DST_Y] = hi_f;
                    end
                    A_SRC_XY: begin
                        coord_we[CI_SRC_Y] = 1'b1; coord_wv[CI_SRC_Y] = lo_f;
                        coord_we[CI_SRC_X] = 1'b1; coord_wv[CI_SRC_X] = hi_f;
                    end
                    A_DST_XY: begin
                        coord_we[CI_DST_Y] = 1'b1; coord_wv[CI_DST_Y] = lo_f;
                        coord_we[CI_DST_X] = 1'b1; coord_wv[CI_DST_X] = hi_f;
                    end
                    A_HT_WD: begin
                        coord_we[CI_WIDTH]  = 1'b1; coord_wv[CI_WIDTH]  = lo_f;
                        coord_we[CI_HEIGHT] = 1'b1; coord_wv[CI_HEIGHT] = hi_f;
                        start_req = 1'b1;
                    end
                    A_WD_HT: begin
                        coord_we[CI_HEIGHT] = 1'b1; coord_wv[CI_HEIGHT] = lo_f;
                        coord_we[CI_WIDTH]  = 1'b1; coord_wv[CI_WIDTH]  = hi_f;
                        start_req = 1'b1;
                    end
                    A_WD_X: begin
                        coord_we[CI_DST_X] = 1'b1; coord_wv[CI_DST_X] = lo_f;
                        coord_we[CI_WIDTH] = 1'b1; coord_wv[CI_WIDTH] = hi_f;
                        start_req = 1'b1;
                    end
                    A_HT_Y: begin
                        coord_we[CI_DST_Y]  = 1'b1; coord_wv[CI_DST_Y]  = lo_f;
                        coord_we[CI_HEIGHT] = 1'b1; coord_wv[CI_HEIGHT] = hi_f;
                    end
                    A_CTRL: begin
                        ctrl_we  = 1'b1;
                        ctrl_wv  = wr_data & CTRL_MASK;
                        dtype_we = 1'b1;
                        dtype_wv = ctrl_to_dtype(wr_data);
                        mix_we   = 1'b1;
                        mix_wv   = ctrl_to_mix(wr_data);
                    end
                    A_DTYPE: begin
                        dtype_we = 1'b1;
                        dtype_wv = wr_data & DTYPE_MASK;
                    end
                    A_MIX: begin
                        mix_we = 1'b1;
                        mix_wv = wr_data & MIX_MASK;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/blit_reg_bank.sv
// Register bank: holds the geometry, surface and control registers,
// exposes both the stored and next-cycle values, and serves reads.
// Assumes the decoder never enables two values for one field at once.
module blit_reg_bank
    import blit_setup_pkg::*;
#(
    parameter int COORD_W = 14,
    parameter int PITCH_W = 14
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_COORD-1:0]                   coord_we,
    input  logic [N_COORD-1:0][COORD_W-1:0]      coord_wv,
    input  logic [N_SURF-1:0]                    offs_we,
    input  logic [N_SURF-1:0][DATA_W-1:0]        offs_wv,
    input  logic [N_SURF-1:0]                    pitch_we,
    input  logic [N_SURF-1:0][PITCH_W-1:0]       pitch_wv,
    input  logic [N_SURF-1:0]                    tile_wv,
    input  logic                                 ctrl_we,
    input  logic [DATA_W-1:0]                    ctrl_wv,
    input  logic                                 dtype_we,
    input  logic [DATA_W-1:0]                    dtype_wv,
    input  logic                                 mix_we,
    input  logic [DATA_W-1:0]                    mix_wv,
    output logic [N_COORD-1:0][COORD_W-1:0]      coord_nx,
    output logic [N_SURF-1:0][DATA_W-1:0]        offs_nx,
    output logic [N_SURF-1:0][PITCH_W-1:0]       pitch_nx,
    output logic [N_SURF-1:0]                    tile_nx,
    output logic [DATA_W-1:0]                    dtype_nx,
    output logic [DATA_W-1:0]                    mix_nx,
    input  logic [REG_ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                    rd_data
);

    localparam int CI_W     = $clog2(N_COORD);
    localparam int TILE_BIT = 16;

    logic [N_COORD-1:0][COORD_W-1:0] coord_q;
    logic [N_SURF-1:0][DATA_W-1:0]   offs_q;
    logic [N_SURF-1:0][PITCH_W-1:0]  pitch_q;
    logic [N_SURF-1:0]               tile_q;
    logic [DATA_W-1:0]               ctrl_q;
    logic [DATA_W-1:0]               dtype_q;
    logic [DATA_W-1:0]               mix_q;

    genvar gi;
    generate
        for (gi = 0; gi < N_COORD; gi++) begin : g_coord
            assign coord_nx[gi] = coord_we[gi] ? coord_wv[gi] : coord_q[gi];
            // Coordinate slot storage
            always_ff @(posedge clk) begin
                if (!rst_n) coord_q[gi] <= '0;
                else        coord_q[gi] <= coord_nx[gi];
            end
        end
        for (gi = 0; gi < N_SURF; gi++) begin : g_surf
            assign offs_nx[gi]  = offs_we[gi]  ? offs_wv[gi]  : offs_q[gi];
            assign pitch_nx[gi] = pitch_we[gi] ? pitch_wv[gi] : pitch_q[gi];
            assign tile_nx[gi]  = pitch_we[gi] ? tile_wv[gi]  : tile_q[gi];
            // Surface offset, pitch and tile storage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    offs_q[gi]  <= '0;
                    pitch_q[gi] <= '0;
                    tile_q[gi]  <= 1'b0;
                end else begin
                    offs_q[gi]  <= offs_nx[gi];
                    pitch_q[gi] <= pitch_nx[gi];
                    tile_q[gi]  <= tile_nx[gi];
                end
            end
        end
    endgenerate

    assign dtype_nx = dtype_we ? dtype_wv : dtype_q;
    assign mix_nx   = mix_we   ? mix_wv   : mix_q;

    // Control, datatype and mix storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            dtype_q <= '0;
            mix_q   <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wv;
            dtype_q <= dtype_nx;
            mix_q   <= mix_nx;
        end
    end

    // Read multiplexer over stored values
    always_comb begin
        rd_data = '0;
        if (rd_addr < REG_ADDR_W'(N_COORD)) begin
            rd_data = DATA_W'(coord_q[rd_addr[CI_W-1:0]]);
        end else begin
            case (rd_addr)
                A_SRC_OFFS:  rd_data = offs_q[SURF_SRC];
                A_DST_OFFS:  rd_data = offs_q[SURF_DST];
                A_SRC_PITCH: rd_data = DATA_W'(pitch_q[SURF_SRC]) |
                                       (DATA_W'(tile_q[SURF_SRC]) << TILE_BIT);
                A_DST_PITCH: rd_data = DATA_W'(pitch_q[SURF_DST]) |
                                       (DATA_W'(tile_q[SURF_DST]) << TILE_BIT);
                A_CTRL:      rd_data = ctrl_q;
                A_DTYPE:     rd_data = dtype_q;
                A_MIX:       rd_data = mix_q;
                default:     rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/blit_launch.sv
// Launch control: issues a one-cycle start with a parameter snapshot,
// defers requests made while the engine is busy until it goes idle.
// Assumes params_nx already includes the write of the current cycle.
module blit_launch #(
    parameter int PARAM_W = 242
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               eng_busy,
    input  logic [PARAM_W-1:0] params_nx,
    output logic               start,
    output logic [PARAM_W-1:0] params_q,
    output logic               pending
);

    logic fire;

    assign fire = (start_req | pending) & ~eng_busy;

    // Pending request tracking and start pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            start   <= 1'b0;
        end else begin
            pending <= eng_busy & (pending | start_req);
            start   <= fire;
        end
    end

    // Parameter snapshot taken at each launch
    always_ff @(posedge clk) begin
        if (!rst_n)    params_q <= '0;
        else if (fire) params_q <= params_nx;
    end

endmodule

// File: rtl/blit_setup_regs.sv
// Top of the blit setup front-end: decoder, register bank and launch
// control. Outputs hold the parameters captured at the latest start.
// Assumes one full-word write per cycle and a single downstream engine.
module blit_setup_regs
    import blit_setup_pkg::*;
#(
    parameter int COORD_W = 14,
    parameter int PITCH_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  eng_busy,
    output logic                  blit_start,
    output logic [COORD_W-1:0]    out_src_x,
    output logic [COORD_W-1:0]    out_src_y,
    output logic [COORD_W-1:0]    out_dst_x,
    output logic [COORD_W-1:0]    out_dst_y,
    output logic [COORD_W-1:0]    out_width,
    output logic [COORD_W-1:0]    out_height,
    output logic [DATA_W-1:0]     out_src_offset,
    output logic [PITCH_W-1:0]    out_src_pitch,
    output logic                  out_src_tile,
    output logic [DATA_W-1:0]     out_dst_offset,
    output logic [PITCH_W-1:0]    out_dst_pitch,
    output logic                  out_dst_tile,
    output logic [DATA_W-1:0]     out_datatype,
    output logic [DATA_W-1:0]     out_mix
);

    localparam int SURF_W  = DATA_W + PITCH_W + 1;
    localparam int PARAM_W = N_COORD * COORD_W + N_SURF * SURF_W + 2 * DATA_W;

    logic [N_COORD-1:0]              coord_we;
    logic [N_COORD-1:0][COORD_W-1:0] coord_wv, coord_nx;
    logic [N_SURF-1:0]               offs_we, pitch_we, tile_wv, tile_nx;
    logic [N_SURF-1:0][DATA_W-1:0]   offs_wv, offs_nx;
    logic [N_SURF-1:0][PITCH_W-1:0]  pitch_wv, pitch_nx;
    logic                            ctrl_we, dtype_we, mix_we, start_req;
    logic [DATA_W-1:0]               ctrl_wv, dtype_wv, mix_wv, dtype_nx, mix_nx;
    logic [PARAM_W-1:0]              params_nx, params_q;
    logic                            launch_pending;

    blit_wr_decode #(.COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_decode (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .coord_we  (coord_we),
        .coord_wv  (coord_wv),
        .offs_we   (offs_we),
        .offs_wv   (offs_wv),
        .pitch_we  (pitch_we),
        .pitch_wv  (pitch_wv),
        .tile_wv   (tile_wv),
        .ctrl_we   (ctrl_we),
        .ctrl_wv   (ctrl_wv),
        .dtype_we  (dtype_we),
        .dtype_wv  (dtype_wv),
        .mix_we    (mix_we),
        .mix_wv    (mix_wv),
        .start_req (start_req)
    );

    blit_reg_bank #(.COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .coord_we (coord_we),
        .coord_wv (coord_wv),
        .offs_we  (offs_we),
        .offs_wv  (offs_wv),
        .pitch_we (pitch_we),
        .pitch_wv (pitch_wv),
        .tile_wv  (tile_wv),
        .ctrl_we  (ctrl_we),
        .ctrl_wv  (ctrl_wv),
        .dtype_we (dtype_we),
        .dtype_wv (dtype_wv),
        .mix_we   (mix_we),
        .mix_wv   (mix_wv),
        .coord_nx (coord_nx),
        .offs_nx  (offs_nx),
        .pitch_nx (pitch_nx),
        .tile_nx  (tile_nx),
        .dtype_nx (dtype_nx),
        .mix_nx   (mix_nx),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign params_nx = {coord_nx,
                        offs_nx[SURF_SRC], pitch_nx[SURF_SRC], tile_nx[SURF_SRC],
                        offs_nx[SURF_DST], pitch_nx[SURF_DST], tile_nx[SURF_DST],
                        dtype_nx, mix_nx};

    blit_launch #(.PARAM_W(PARAM_W)) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .eng_busy  (eng_busy),
        .params_nx (params_nx),
        .start     (blit_start),
        .params_q  (params_q),
        .pending   (launch_pending)
    );

    assign {out_height, out_width, out_dst_y, out_dst_x, out_src_y, out_src_x,
            out_src_offset, out_src_pitch, out_src_tile,
            out_dst_offset, out_dst_pitch, out_dst_tile,
            out_datatype, out_mix} = params_q;

endmodule

// File: rtl/blit_setup_regs_chk.sv
// Checker for the blit setup front-end: start triggering, busy deferral
// and snapshot contents, attached to the top module with bind.
module blit_setup_regs_chk
    import blit_setup_pkg::*;
#(
    parameter int COORD_W = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  eng_busy,
    input logic                  blit_start,
    input logic [COORD_W-1:0]    out_width,
    input logic [COORD_W-1:0]    out_height,
    input logic                  pend
);

    AST_WIDTH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_DST_W && !eng_busy |=> blit_start); // R3

    AST_HEIGHT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_DST_H && !pend |=> !blit_start); // R3

    AST_HT_WD_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_HT_WD && !eng_busy
        |=> blit_start && out_height == $past(wr_data[29:16])); // R4

    AST_HT_Y_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_HT_Y && !pend |=> !blit_start); // R5

    AST_SNAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_DST_W && !eng_busy
        |=> out_width == $past(wr_data[COORD_W-1:0])); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !blit_start); // R10

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy && wr_en && wr_addr == A_DST_W |=> pend); // R10

    AST_PEND_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !eng_busy |=> blit_start && !pend); // R10

endmodule

bind blit_setup_regs blit_setup_regs_chk #(.COORD_W(COORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .eng_busy   (eng_busy),
    .blit_start (blit_start),
    .out_width  (out_width),
    .out_height (out_height),
    .pend       (launch_pending)
);

// File: tb/blit_setup_regs_bench.sv
`timescale 1ns/1ps
module blit_setup_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_busy = 1'b0;
    logic        blit_start;
    logic [13:0] out_src_x, out_src_y, out_dst_x, out_dst_y, out_width, out_height;
    logic [31:0] out_src_offset, out_dst_offset, out_datatype, out_mix;
    logic [13:0] out_src_pitch, out_dst_pitch;
    logic        out_src_tile, out_dst_tile;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    blit_setup_regs u_blit_setup_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_busy(eng_busy), .blit_start(blit_start),
        .out_src_x(out_src_x), .out_src_y(out_src_y), .out_dst_x(out_dst_x),
        .out_dst_y(out_dst_y), .out_width(out_width), .out_height(out_height),
        .out_src_offset(out_src_offset), .out_src_pitch(out_src_pitch),
        .out_src_tile(out_src_tile), .out_dst_offset(out_dst_offset),
        .out_dst_pitch(out_dst_pitch), .out_dst_tile(out_dst_tile),
        .out_datatype(out_datatype), .out_mix(out_mix)
    );

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] data;
        logic        start;
        logic [5:0]  chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 32'hFFFF_C123, 1'b0, 6'h00, 32'h0000_0123, 4'd2},  // R2 mask
        '{6'h05, 32'h0001_7FFF, 1'b0, 6'h05, 32'h0000_3FFF, 4'd3},  // R3 height no start
        '{6'h04, 32'h1234_5678, 1'b1, 6'h04, 32'h0000_1678, 4'd3},  // R3 width starts
        '{6'h10, 32'h2ABC_1111, 1'b1, 6'h05, 32'h0000_2ABC, 4'd4},  // R4
        '{6'h11, 32'h0055_0066, 1'b1, 6'h04, 32'h0000_0055, 4'd4},  // R4
        '{6'h12, 32'h0100_0200, 1'b1, 6'h02, 32'h0000_0200, 4'd4},  // R4
        '{6'h13, 32'h0300_0400, 1'b0, 6'h05, 32'h0000_0300, 4'd5},  // R5
        '{6'h0C, 32'h0011_0022, 1'b0, 6'h01, 32'h0000_0011, 4'd5},  // R5
        '{6'h0F, 32'h0033_0044, 1'b0, 6'h03, 32'h0000_0044, 4'd5},  // R5
        '{6'h0E, 32'h0077_0088, 1'b0, 6'h00, 32'h0000_0077, 4'd5},  // R5
        '{6'h0D, 32'hC005_C006, 1'b0, 6'h02, 32'h0000_0006, 4'd5},  // R5
        '{6'h0A, 32'hAAA0_0003, 1'b0, 6'h06, 32'h0000_0060, 4'd6},  // R6
        '{6'h0B, 32'h7FFF_FFFF, 1'b0, 6'h09, 32'h0000_03FF, 4'd6},  // R6
        '{6'h06, 32'hDEAD_BEEF, 1'b0, 6'h06, 32'hDEAD_BEE0, 4'd7},  // R7
        '{6'h07, 32'hFFFF_FFFF, 1'b0, 6'h07, 32'h0001_3FFF, 4'd7},  // R7
        '{6'h14, 32'hFFFF_FFFF, 1'b0, 6'h14, 32'hF800_000F, 4'd8},  // R8
        '{6'h14, 32'h0000_7FF0, 1'b0, 6'h15, 32'h4003_0F0F, 4'd8},  // R8
        '{6'h14, 32'h0567_89AB, 1'b0, 6'h16, 32'h0067_0500, 4'd8},  // R8
        '{6'h15, 32'hFFFF_FFFF, 1'b0, 6'h15, 32'hE007_0F0F, 4'd8},  // R8
        '{6'h3F, 32'hFFFF_FFFF, 1'b0, 6'h00, 32'h0000_0077, 4'd11}, // R11
        '{6'h3E, 32'hFFFF_FFFF, 1'b0, 6'h10, 32'h0000_0000, 4'd11}  // R11
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one write; returns at the falling edge after the capturing edge
    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input int req, input logic [5:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, $sformatf("read 0x%h", a), rd_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(1, "start after reset", 32'(blit_start), 32'd0);
        check(1, "width snapshot after reset", 32'(out_width), 32'd0);
        check(1, "mix snapshot after reset", out_mix, 32'd0);
        check_rd(1, 6'h04, 32'd0);
        check_rd(1, 6'h07, 32'd0);
        check_rd(1, 6'h16, 32'd0);

        // Table walk: one write, then start and a register read
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].data);
            check(int'(VECS[i].req), $sformatf("start after vector %0d", i),
                  32'(blit_start), 32'(VECS[i].start));
            check_rd(int'(VECS[i].req), VECS[i].chk, VECS[i].exp);
        end

        // R9: snapshot carries every register, pulse lasts one cycle
        do_write(6'h04, 32'h0000_0AAA);
        check(9, "start on width", 32'(blit_start), 32'd1);
        check(9, "snap width", 32'(out_width), 32'h0AAA);
        check(9, "snap height", 32'(out_height), 32'h0300);
        check(9, "snap src y", 32'(out_src_y), 32'h0088);
        check(9, "snap dst y", 32'(out_dst_y), 32'h0005);
        check(7, "snap src offset", out_src_offset, 32'hDEAD_BEE0);
        check(7, "snap src pitch", 32'(out_src_pitch), 32'h3FFF);
        check(7, "snap src tile", 32'(out_src_tile), 32'd1);
        check(6, "snap dst offset", out_dst_offset, 32'h03FF_FFE0);
        check(6, "snap dst pitch", 32'(out_dst_pitch), 32'h03FF);
        check(6, "snap dst tile", 32'(out_dst_tile), 32'd0);
        check(8, "snap datatype", out_datatype, 32'hE007_0F0F);
        check(8, "snap mix", out_mix, 32'h0067_0500);
        do_write(6'h05, 32'h0000_0099);
        check(9, "pulse one cycle", 32'(blit_start), 32'd0);
        check(9, "snap holds height", 32'(out_height), 32'h0300);

        // R10: request while busy is deferred until busy falls
        @(negedge clk);
        eng_busy = 1'b1;
        do_write(6'h04, 32'h0000_0030);
        check(10, "no start while busy", 32'(blit_start), 32'd0);
        do_write(6'h04, 32'h0000_0031);
        check(10, "no start second request", 32'(blit_start), 32'd0);
        do_write(6'h02, 32'h0000_0005);
        check(10, "still no start", 32'(blit_start), 32'd0);
        eng_busy = 1'b0;
        @(negedge clk);
        check(10, "deferred start", 32'(blit_start), 32'd1);
        check(10, "deferred width", 32'(out_width), 32'h0031);
        check(10, "deferred dst x", 32'(out_dst_x), 32'h0005);
        @(negedge clk);
        check(10, "single deferred start", 32'(blit_start), 32'd0);

        // R11: writes to unmapped addresses leave the snapshot alone
        do_write(6'h2A, 32'hFFFF_FFFF);
        check(11, "unmapped no start", 32'(blit_start), 32'd0);
        check_rd(11, 6'h04, 32'h0000_0031);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule